// File: doc/BRIEF.md
# DMA Request Serializer with Grant Decode

This block lets seven legacy DMA channels (0, 1, 2, 3, 5, 6, 7) share one request wire and one grant wire with a host. Whenever the set of active channel requests changes, the block sends a request frame on the active-low request line: one low start clock, then one clock per slot carrying each channel's request level. Slot 4 has no channel and is always sent inactive.

The host answers on the active-low grant line. A grant frame is one low start clock followed by the granted channel number, least significant bit first. The block then drives the acknowledge of that channel and holds it while the host keeps the grant line low. Data transfers for the granted channel arrive as decoded host I/O cycles. An I/O cycle whose address bit 2 is set marks the last transfer. The block answers it with a one-clock terminal-count pulse and then drops the acknowledge.

Top module: `dma_serial_link`

## Requirements
- R1: After reset the request line is high, every acknowledge is high and the terminal-count output is low.
- R2: When the masked request vector differs from the one last reported, the request line goes low for one start clock. It then carries slots 0 to 7 in ascending order, one per clock, each low exactly when that channel's request was high at the start clock. After the last slot the line returns high.
- R3: Slot 4 is always sent high, and a change on request input 4 alone never starts a frame.
- R4: Between the last slot of one frame and the next start clock the line stays high for at least one clock. It stays high for at least two clocks when a grant frame completed after the previous start clock. A grant that completes in the same clock as a start counts toward the following frame.
- R5: A grant frame is a low start clock followed by three bits, LSB first, with a high line read as 1. The acknowledge of that channel goes low in the clock after the last bit is sampled.
- R6: A grant of channel 4 drives no acknowledge and never produces a terminal-count pulse.
- R7: At most one acknowledge is low at any time.
- R8: While a channel is acknowledged, a high grant line at a clock edge releases the acknowledge after that edge, and a simultaneous I/O cycle produces no terminal count.
- R9: An I/O strobe with address bit 2 set (input io_tc_i high), sampled while a valid channel is acknowledged and the grant line is low, makes the terminal-count output high for exactly the next clock with the acknowledge still low. The acknowledge rises one clock later. A new grant frame is accepted only after the grant line has been seen high.
- R10: An I/O strobe with address bit 2 clear, or a strobe while no channel is acknowledged, changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dreq_i | input | NUM_SLOTS | Channel requests, active high, bit = channel |
| gnt_n_i | input | 1 | Serial grant line from the host |
| io_strobe_i | input | 1 | One-clock pulse for a decoded DMA I/O cycle |
| io_tc_i | input | 1 | Address bit 2 of that I/O cycle |
| req_n_o | output | 1 | Serial request line to the host |
| dack_n_o | output | NUM_SLOTS | Channel acknowledges, active low |
| tc_o | output | 1 | Terminal-count pulse |

## Verification
The request serializer and the grant decoder run at the same time. The case that matters is a grant frame whose last bit is sampled in the very clock a new request frame starts. The bench changes the request vector and then starts a grant frame at a sweep of offsets from zero to eleven clocks, so one of the offsets lands on that coincidence. The behavioural model decides the gap length before the next frame, and the gap on the request line is compared with it on every clock.

// File: rtl/dma_ser_pkg.sv
package dma_ser_pkg;

    typedef enum logic [1:0] {
        F_IDLE,
        F_START,
        F_DATA
    } frm_state_e;

    typedef enum logic [2:0] {
        G_IDLE,
        G_CHAN,
        G_HELD,
        G_TCEND,
        G_DRAIN
    } gnt_state_e;

endpackage

// File: rtl/dma_req_framer.sv
module dma_req_framer
    import dma_ser_pkg::*;
#(
    parameter int                   NUM_SLOTS = 8,
    parameter logic [NUM_SLOTS-1:0] SLOT_MASK = '1,
    parameter int                   CH_W      = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] dreq_i,
    input  logic                 grant_evt_i,
    output logic                 req_n_o
);

    localparam logic [1:0] RUN_MAX = 2'd3;
    localparam logic [CH_W-1:0] LAST_SLOT = CH_W'(NUM_SLOTS - 1);

    typedef struct packed {
        frm_state_e           st;
        logic [CH_W-1:0]      slot;
        logic [NUM_SLOTS-1:0] snap;
        logic                 req_n;
        logic [1:0]           run;
        logic                 gflag;
    } frm_t;

    frm_t q, d;
    logic [NUM_SLOTS-1:0] masked;
    logic [1:0]           need;

    always_comb begin
        d      = q;
        masked = dreq_i & SLOT_MASK;
        need   = q.gflag ? 2'd2 : 2'd1;
        case (q.st)
            F_IDLE: begin
                if ((masked != q.snap) && (q.run >= need)) begin
                    d.st    = F_START;
                    d.req_n = 1'b0;
                    d.snap  = masked;
                    d.gflag = 1'b0;
                end else if (q.run != RUN_MAX) begin
                    d.run = q.run + 2'd1;
                end
            end
            F_START: begin
                d.st    = F_DATA;
                d.slot  = '0;
                d.req_n = ~q.snap[0];
            end
            F_DATA: begin
                if (q.slot == LAST_SLOT) begin
                    d.st    = F_IDLE;
                    d.req_n = 1'b1;
                    d.run   = 2'd1;
                end else begin
                    d.slot  = q.slot + 1'b1;
                    d.req_n = ~q.snap[q.slot + 1'b1];
                end
            end
            default: d.st = F_IDLE;
        endcase
        if (grant_evt_i) d.gflag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: F_IDLE, slot: '0, snap: '0, req_n: 1'b1, run: RUN_MAX, gflag: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign req_n_o = q.req_n;

endmodule

// File: rtl/dma_gnt_decoder.sv
module dma_gnt_decoder
    import dma_ser_pkg::*;
#(
    parameter int                   NUM_SLOTS = 8,
    parameter logic [NUM_SLOTS-1:0] SLOT_MASK = '1,
    parameter int                   CH_W      = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gnt_n_i,
    input  logic                 io_strobe_i,
    input  logic                 io_tc_i,
    output logic                 grant_evt_o,
    output logic [NUM_SLOTS-1:0] dack_n_o,
    output logic                 tc_o
);

    localparam logic [CH_W-1:0] LAST_BIT = CH_W'(CH_W - 1);

    typedef struct packed {
        gnt_state_e      st;
        logic [CH_W-1:0] bitn;
        logic [CH_W-1:0] ch;
        logic            act;
        logic            tc;
    } gnt_t;

    gnt_t q, d;

    always_comb begin
        d           = q;
        d.tc        = 1'b0;
        grant_evt_o = (q.st == G_CHAN) && (q.bitn == LAST_BIT);
        case (q.st)
            G_IDLE: begin
                if (!gnt_n_i) begin
                    d.st   = G_CHAN;
                    d.bitn = '0;
                    d.ch   = '0;
                end
            end
            G_CHAN: begin
                d.ch[q.bitn] = gnt_n_i;
                if (q.bitn == LAST_BIT) begin
                    d.st  = G_HELD;
                    d.act = 1'b1;
                end else begin
                    d.bitn = q.bitn + 1'b1;
                end
            end
            G_HELD: begin
                if (gnt_n_i) begin
                    d.act = 1'b0;
                    d.st  = G_IDLE;
                end else if (io_strobe_i && io_tc_i && SLOT_MASK[q.ch]) begin
                    d.tc = 1'b1;
                    d.st = G_TCEND;
                end
            end
            G_TCEND: begin
                d.act = 1'b0;
                d.st  = gnt_n_i ? G_IDLE : G_DRAIN;
            end
            G_DRAIN: begin
                if (gnt_n_i) d.st = G_IDLE;
            end
            default: d.st = G_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: G_IDLE, bitn: '0, ch: '0, act: 1'b0, tc: 1'b0};
        end else begin
            q <= d;
        end
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_ack
        assign dack_n_o[i] = ~(q.act & SLOT_MASK[i] & (q.ch == CH_W'(i)));
    end

    assign tc_o = q.tc;

endmodule

// File: rtl/dma_serial_link.sv
module dma_serial_link #(
    parameter int NUM_SLOTS = 8,
    parameter int HOLE_CH   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] dreq_i,
    input  logic                 gnt_n_i,
    input  logic                 io_strobe_i,
    input  logic                 io_tc_i,
    output logic                 req_n_o,
    output logic [NUM_SLOTS-1:0] dack_n_o,
    output logic                 tc_o
);

    localparam int                   CH_W      = $clog2(NUM_SLOTS);
    localparam logic [NUM_SLOTS-1:0] SLOT_MASK = ~(NUM_SLOTS'(1) << HOLE_CH);

    logic grant_evt;

    dma_req_framer #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_MASK (SLOT_MASK),
        .CH_W      (CH_W)
    ) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .dreq_i      (dreq_i),
        .grant_evt_i (grant_evt),
        .req_n_o     (req_n_o)
    );

    dma_gnt_decoder #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_MASK (SLOT_MASK),
        .CH_W      (CH_W)
    ) u_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .gnt_n_i     (gnt_n_i),
        .io_strobe_i (io_strobe_i),
        .io_tc_i     (io_tc_i),
        .grant_evt_o (grant_evt),
        .dack_n_o    (dack_n_o),
        .tc_o        (tc_o)
    );

endmodule

// File: rtl/dma_serial_link_chk.sv
module dma_serial_link_chk #(
    parameter int NUM_SLOTS = 8,
    parameter int HOLE_CH   = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 gnt_n_i,
    input logic                 io_strobe_i,
    input logic                 io_tc_i,
    input logic [NUM_SLOTS-1:0] dack_n_o,
    input logic                 tc_o
);

    // R7
    one_dack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~dack_n_o));

    // R6
    hole_dack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dack_n_o[HOLE_CH]);

    // R9
    tc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |=> !tc_o);

    // R9
    tc_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |-> !(&dack_n_o));

    // R9
    tc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |=> (&dack_n_o));

    // R9
    tc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tc_o) |-> $past(io_strobe_i && io_tc_i && !gnt_n_i));

    // R8
    gnt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&dack_n_o) && !tc_o && gnt_n_i) |=> ((&dack_n_o) && !tc_o));

endmodule

bind dma_serial_link dma_serial_link_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .HOLE_CH   (HOLE_CH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gnt_n_i     (gnt_n_i),
    .io_strobe_i (io_strobe_i),
    .io_tc_i     (io_tc_i),
    .dack_n_o    (dack_n_o),
    .tc_o        (tc_o)
);

// File: tb/dma_serial_link_bench.sv
`timescale 1ns/1ps
module dma_serial_link_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] dreq = 8'h00;
    logic       gnt = 1'b1;
    logic       stb = 1'b0;
    logic       tcb = 1'b0;
    logic       req_n;
    logic [7:0] dack_n;
    logic       tc;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    dma_serial_link u_dma_serial_link (
        .clk         (clk),
        .rst_n       (rst_n),
        .dreq_i      (dreq),
        .gnt_n_i     (gnt),
        .io_strobe_i (stb),
        .io_tc_i     (tcb),
        .req_n_o     (req_n),
        .dack_n_o    (dack_n),
        .tc_o        (tc)
    );

    // behavioural reference model
    int         m_ph, m_run, m_gst, m_bit;
    logic [7:0] m_snap;
    logic [2:0] m_ch;
    logic       m_req_n, m_gflag, m_act, m_tc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = -1; m_snap = 8'h00; m_req_n = 1'b1; m_run = 3; m_gflag = 1'b0;
            m_gst = 0; m_bit = 0; m_ch = 3'd0; m_act = 1'b0; m_tc = 1'b0;
        end else begin
            logic gevt, nflag;
            logic [7:0] dm;
            gevt  = (m_gst == 1) && (m_bit == 2);
            dm    = dreq & 8'hEF;
            nflag = m_gflag;
            if (m_ph < 0) begin
                if (dm != m_snap && m_run >= (m_gflag ? 2 : 1)) begin
                    m_ph = 0; m_req_n = 1'b0; m_snap = dm; nflag = 1'b0;
                end else if (m_run < 3) begin
                    m_run++;
                end
            end else if (m_ph < 8) begin
                m_req_n = ~m_snap[m_ph];
                m_ph++;
            end else begin
                m_ph = -1; m_req_n = 1'b1; m_run = 1;
            end
            if (gevt) nflag = 1'b1;
            m_gflag = nflag;
            m_tc = 1'b0;
            case (m_gst)
                0: if (!gnt) begin m_gst = 1; m_bit = 0; m_ch = 3'd0; end
                1: begin
                    m_ch[m_bit] = gnt;
                    if (m_bit == 2) begin m_gst = 2; m_act = 1'b1; end
                    else m_bit++;
                end
                2: begin
                    if (gnt) begin m_act = 1'b0; m_gst = 0; end
                    else if (stb && tcb && m_ch != 3'd4) begin m_tc = 1'b1; m_gst = 3; end
                end
                3: begin m_act = 1'b0; m_gst = gnt ? 0 : 4; end
                4: if (gnt) m_gst = 0;
                default: m_gst = 0;
            endcase
        end
    end

    function automatic logic [7:0] exp_dack();
        logic [7:0] v = 8'hFF;
        if (m_act && m_ch != 3'd4) v[m_ch] = 1'b0;
        return v;
    endfunction

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(req_n === m_req_n, cur_tag, "req_n", 32'(req_n), 32'(m_req_n));
            check(dack_n === exp_dack(), cur_tag, "dack_n", 32'(dack_n), 32'(exp_dack()));
            check(tc === m_tc, cur_tag, "tc", 32'(tc), 32'(m_tc));
            // R7: never more than one acknowledge
            check($countones(~dack_n) <= 1, "R7", "dack_count", 32'($countones(~dack_n)), 32'd1);
            // R3: slot 4 is high on the line
            if (m_ph == 5) check(req_n === 1'b1, "R3", "slot4", 32'(req_n), 32'd1);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_grant(input logic [2:0] ch);
        gnt = 1'b0; cyc(1);
        for (int i = 0; i < 3; i++) begin
            gnt = ch[i]; cyc(1);
        end
        gnt = 1'b0;
    endtask

    task automatic pulse_io(input logic tc_bit);
        stb = 1'b1; tcb = tc_bit; cyc(1);
        stb = 1'b0; tcb = 1'b0;
    endtask

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        check(req_n === 1'b1, "R1", "req_n", 32'(req_n), 32'd1);
        check(dack_n === 8'hFF, "R1", "dack_n", 32'(dack_n), 32'hFF);
        check(tc === 1'b0, "R1", "tc", 32'(tc), 32'd0);
        cyc(2);

        cur_tag = "R2";
        dreq = 8'hA5; cyc(14);
        dreq = 8'h02; cyc(14);

        cur_tag = "R3";
        dreq = 8'h12; cyc(14);
        dreq = 8'hFF; cyc(14);

        cur_tag = "R5";
        send_grant(3'd5); cyc(3);
        cur_tag = "R10";
        pulse_io(1'b0); cyc(3);
        cur_tag = "R9";
        pulse_io(1'b1); cyc(4);
        send_grant(3'd1); cyc(2);
        gnt = 1'b1; cyc(2);

        cur_tag = "R4";
        dreq = 8'h00; cyc(14);
        dreq = 8'h81; cyc(3);
        dreq = 8'h08; cyc(20);

        cur_tag = "R6";
        send_grant(3'd4); cyc(2);
        pulse_io(1'b1); cyc(3);
        gnt = 1'b1; cyc(2);

        cur_tag = "R8";
        send_grant(3'd0); cyc(3);
        gnt = 1'b1; cyc(3);
        send_grant(3'd7);
        gnt = 1'b1; cyc(3);
        send_grant(3'd6); cyc(2);
        gnt = 1'b1; stb = 1'b1; tcb = 1'b1; cyc(1);
        stb = 1'b0; tcb = 1'b0; cyc(3);

        cur_tag = "R10";
        pulse_io(1'b1); cyc(3);
        pulse_io(1'b0); cyc(3);

        cur_tag = "R4";
        for (int off = 0; off < 12; off++) begin
            dreq = off[0] ? 8'h03 : 8'h0C;
            cyc(off);
            send_grant(3'd2); cyc(2);
            gnt = 1'b1; cyc(1);
            dreq = off[0] ? 8'h40 : 8'h20;
            cyc(24);
        end

        cyc(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule